// File: doc/BRIEF.md
# Display Controller Serial Command Decoder

This block is the command front end of a multiplexed display controller. A host shifts bytes in over a three-wire link made of an active-low strobe, a shift clock and a data line. The block runs on the system clock and oversamples the three wires. It frames the bytes, decodes the first byte of every strobe window as a command, and keeps the controller's configuration registers up to date. These registers hold the display geometry, the display enable, the brightness step and the key-scan enable.

When a strobe window opens with an address command, the bytes that follow are written into a byte-wide display memory. They go to the location held by an address pointer, which either advances or holds after each write. The display refresh logic reads this memory through a combinational read port, and it takes the digit and segment counts from the decoder's outputs.

Top module: `dcd_cmd_decoder`

## Requirements
- R1: While `ser_stb_n` is low, `ser_dat` is sampled on each rising edge of `ser_clk`, least significant bit first, and every eighth edge completes one byte.
- R2: The first complete byte after `ser_stb_n` falls is a command, and its bits 7:6 select the class: 00 mode, 01 data setting, 10 display control, 11 address setting. A later byte in the same window is never taken as a command.
- R3: A mode command whose code (bits 2:0) differs from the current code loads the new code, clears `disp_on` and clears `key_scan_en`.
- R4: A mode command whose code equals the current code changes nothing: `disp_on`, `dim_level` and `key_scan_en` keep their values.
- R5: For mode code c, `disp_digits` is 4+c. `disp_segs` is 16 for c of 0, 1 or 2, and 18-c for c of 3 to 7.
- R6: A display control command sets `disp_on` from bit 3 and `dim_level` from bits 2:0, and sets `key_scan_en` to 1.
- R7: An address command loads the pointer from bits 4:0. If the last data setting command selected write mode (bits 1:0 = 00), each following byte in the same window is written to memory at the pointer.
- R8: With bit 2 of the data setting command at 0, the pointer increments after every write. With bit 2 at 1, the pointer holds.
- R9: While the pointer is 0x16 or above, data bytes are discarded and the pointer does not move until a new address command arrives.
- R10: If `ser_stb_n` rises before a byte is complete, the partial bits are dropped with no register or memory update, and the next window starts framing afresh.
- R11: After reset every memory byte reads 0, `disp_on` is 0, `dim_level` is 0, `key_scan_en` is 1, the mode code is 0, and auto-increment write mode is selected.
- R12: No memory write happens in two cases: after a data setting command with bits 1:0 other than 00, and for extra bytes in a window that opened with a mode, data setting or display control command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_stb_n | input | 1 | Serial strobe, low while a transaction is open |
| ser_clk | input | 1 | Serial shift clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data, LSB first |
| rd_addr | input | 5 | Display memory read address |
| rd_data | output | 8 | Display memory byte at `rd_addr` (0 when out of range) |
| disp_digits | output | 4 | Active digit count (4 to 11) |
| disp_segs | output | 5 | Active segment count (11 to 16) |
| disp_on | output | 1 | Display enable |
| dim_level | output | 3 | Brightness step, 0 to 7 |
| key_scan_en | output | 1 | Key scanning enabled |

## Verification
The assertions assume that the serial wires change slowly compared with the system clock. Each level of the shift clock and the strobe must last several system cycles, so the synchronizers present a clean edge and data is stable around every rising shift clock. The bench holds every serial level for four system cycles and moves the strobe only while the shift clock is low. It also leaves several cycles between the end of a window and its checks.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  localparam int BYTE_W     = 8;
  localparam int PTR_W      = 5;
  localparam int MEM_DEPTH  = 22;
  localparam int MODE_W     = 3;

  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_DSET = 2'b01,
    CLS_DCTL = 2'b10,
    CLS_ADDR = 2'b11
  } cmd_cls_e;

  function automatic logic [3:0] digits_of(input logic [MODE_W-1:0] code);
    return 4'd4 + {1'b0, code};
  endfunction

  function automatic logic [4:0] segs_of(input logic [MODE_W-1:0] code);
    if (code <= 3'd2) return 5'd16;
    return 5'd18 - {2'b00, code};
  endfunction

endpackage

// File: rtl/dcd_ser_rx.sv
module dcd_ser_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_stb_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic       byte_vld,
  output logic       byte_first,
  output logic [7:0] byte_data
);

  localparam int LAST = SYNC_STAGES - 1;

  // bit 2 strobe, bit 1 shift clock, bit 0 data
  logic [2:0] raw;
  logic [2:0] sq [SYNC_STAGES];
  assign raw = {ser_stb_n, ser_clk, ser_dat};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic [2:0] src;
    if (g == 0) begin : g_head
      assign src = raw;
    end else begin : g_tail
      assign src = sq[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq[g] <= 3'b100;
      else        sq[g] <= src;
    end
  end

  logic stb_n_s, sclk_s, sdat_s;
  assign stb_n_s = sq[LAST][2];
  assign sclk_s  = sq[LAST][1];
  assign sdat_s  = sq[LAST][0];

  logic       sclk_q;
  logic [7:0] sh_q, sh_d;
  logic [2:0] cnt_q, cnt_d;
  logic       first_q, first_d;
  logic       vld_q, vld_d;
  logic [7:0] data_q, data_d;
  logic       bfirst_q, bfirst_d;
  logic       rise;

  assign rise = sclk_s & ~sclk_q;

  always_comb begin
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    first_d  = first_q;
    vld_d    = 1'b0;
    data_d   = data_q;
    bfirst_d = bfirst_q;
    if (stb_n_s) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else if (rise) begin
      sh_d = {sdat_s, sh_q[7:1]};
      if (cnt_q == 3'd7) begin
        cnt_d    = '0;
        vld_d    = 1'b1;
        data_d   = sh_d;
        bfirst_d = first_q;
        first_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      first_q  <= 1'b1;
      vld_q    <= 1'b0;
      data_q   <= '0;
      bfirst_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      first_q  <= first_d;
      vld_q    <= vld_d;
      data_q   <= data_d;
      bfirst_q <= bfirst_d;
    end
  end

  assign byte_vld   = vld_q;
  assign byte_first = bfirst_q;
  assign byte_data  = data_q;

  // R10: a byte is only completed while the strobe was held low
  assert_byte_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> !$past(stb_n_s));

endmodule

// File: rtl/dcd_cmd_dec.sv
module dcd_cmd_dec
  import dcd_pkg::*;
#(
  parameter int          DEPTH    = MEM_DEPTH,
  parameter logic [2:0]  RST_MODE = 3'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_first,
  input  logic [7:0]       byte_data,
  output logic [MODE_W-1:0] mode_code,
  output logic             disp_on,
  output logic [2:0]       dim_level,
  output logic             key_scan_en,
  output logic             ram_we,
  output logic [PTR_W-1:0] ram_waddr,
  output logic [7:0]       ram_wdata
);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic              on_q, on_d;
  logic [2:0]        dim_q, dim_d;
  logic              scan_q, scan_d;
  logic              wr_q, wr_d;
  logic              fixed_q, fixed_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              burst_q, burst_d;
  logic              in_range;
  cmd_cls_e          cls;

  assign cls      = cmd_cls_e'(byte_data[7:6]);
  assign in_range = (32'(ptr_q) < DEPTH);

  always_comb begin
    mode_d  = mode_q;
    on_d    = on_q;
    dim_d   = dim_q;
    scan_d  = scan_q;
    wr_d    = wr_q;
    fixed_d = fixed_q;
    ptr_d   = ptr_q;
    burst_d = burst_q;
    ram_we  = 1'b0;
    if (byte_vld) begin
      if (byte_first) begin
        burst_d = 1'b0;
        unique case (cls)
          CLS_MODE: begin
            if (byte_data[2:0] != mode_q) begin
              mode_d = byte_data[2:0];
              on_d   = 1'b0;
              scan_d = 1'b0;
            end
          end
          CLS_DSET: begin
            wr_d    = (byte_data[1:0] == 2'b00);
            fixed_d = byte_data[2];
          end
          CLS_DCTL: begin
            on_d   = byte_data[3];
            dim_d  = byte_data[2:0];
            scan_d = 1'b1;
          end
          CLS_ADDR: begin
            ptr_d   = byte_data[4:0];
            burst_d = 1'b1;
          end
          default: ;
        endcase
      end else if (burst_q && wr_q && in_range) begin
        ram_we = 1'b1;
        if (!fixed_q) ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= RST_MODE;
      on_q    <= 1'b0;
      dim_q   <= '0;
      scan_q  <= 1'b1;
      wr_q    <= 1'b1;
      fixed_q <= 1'b0;
      ptr_q   <= '0;
      burst_q <= 1'b0;
    end else if (byte_vld) begin
      mode_q  <= mode_d;
      on_q    <= on_d;
      dim_q   <= dim_d;
      scan_q  <= scan_d;
      wr_q    <= wr_d;
      fixed_q <= fixed_d;
      ptr_q   <= ptr_d;
      burst_q <= burst_d;
    end
  end

  assign mode_code   = mode_q;
  assign disp_on     = on_q;
  assign dim_level   = dim_q;
  assign key_scan_en = scan_q;
  assign ram_waddr   = ptr_q;
  assign ram_wdata   = byte_data;

  // R3: a differing mode code blanks the display and stops key scanning
  assert_mode_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_first && byte_data[7:6] == 2'b00 && byte_data[2:0] != mode_q)
      |=> (!on_q && !scan_q && mode_q == $past(byte_data[2:0])));

  // R4: an identical mode code leaves the control state alone
  assert_mode_same_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_first && byte_data[7:6] == 2'b00 && byte_data[2:0] == mode_q)
      |=> ($stable(on_q) && $stable(scan_q) && $stable(dim_q)));

  // R8: fixed-address writes keep the pointer
  assert_fixed_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && fixed_q) |=> $stable(ptr_q));

  // R8: auto-increment writes step the pointer by one
  assert_auto_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !fixed_q) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

  // R9: an out-of-range pointer is frozen by data bytes
  assert_oob_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_first && !in_range) |=> $stable(ptr_q));

endmodule

// File: rtl/dcd_disp_ram.sv
module dcd_disp_ram
  import dcd_pkg::*;
#(
  parameter int DEPTH = MEM_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_addr == PTR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[e] <= '0;
      else if (hit) mem[e] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == PTR_W'(i)) rd_data = mem[i];
    end
  end

  // R9: no write request may target a location past the end
  assert_wr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < DEPTH));

endmodule

// File: rtl/dcd_cmd_decoder.sv
module dcd_cmd_decoder
  import dcd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DEPTH       = MEM_DEPTH,
  parameter logic [2:0] RST_MODE    = 3'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_stb_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [3:0] disp_digits,
  output logic [4:0] disp_segs,
  output logic       disp_on,
  output logic [2:0] dim_level,
  output logic       key_scan_en
);

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic             byte_vld, byte_first;
  logic [7:0]       byte_data;
  logic [MODE_W-1:0] mode_code;
  logic             ram_we;
  logic [PTR_W-1:0] ram_waddr;
  logic [7:0]       ram_wdata;

  dcd_ser_rx #(.SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ser_stb_n  (ser_stb_n),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .byte_vld   (byte_vld),
    .byte_first (byte_first),
    .byte_data  (byte_data)
  );

  dcd_cmd_dec #(.DEPTH(DEPTH), .RST_MODE(RST_MODE)) i_dec (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .byte_vld    (byte_vld),
    .byte_first  (byte_first),
    .byte_data   (byte_data),
    .mode_code   (mode_code),
    .disp_on     (disp_on),
    .dim_level   (dim_level),
    .key_scan_en (key_scan_en),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr),
    .ram_wdata   (ram_wdata)
  );

  dcd_disp_ram #(.DEPTH(DEPTH)) i_ram (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign disp_digits = digits_of(mode_code);
  assign disp_segs   = segs_of(mode_code);

endmodule

// File: tb/test_dcd_cmd_decoder.sv
`timescale 1ns/100ps
module test_dcd_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_stb_n, ser_clk, ser_dat;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic [3:0] disp_digits;
  logic [4:0] disp_segs;
  logic       disp_on;
  logic [2:0] dim_level;
  logic       key_scan_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] exp_ram [22];
  bit exp_wr, exp_fixed;

  always #2.5 clk = ~clk;

  dcd_cmd_decoder i_dcd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ser_stb_n(ser_stb_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .rd_addr(rd_addr), .rd_data(rd_data),
    .disp_digits(disp_digits), .disp_segs(disp_segs), .disp_on(disp_on),
    .dim_level(dim_level), .key_scan_en(key_scan_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_ram(input string req);
    for (int a = 0; a < 22; a++) begin
      rd_addr = 5'(a);
      #1;
      chk(req, rd_data, exp_ram[a]);
    end
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int b = 0; b < n; b++) begin
      ser_dat = v[b];
      #20 ser_clk = 1'b1;
      #20 ser_clk = 1'b0;
    end
  endtask

  task automatic open_win();  ser_stb_n = 1'b0; #20; endtask
  task automatic close_win(); #20 ser_stb_n = 1'b1; #60; endtask

  task automatic one_cmd(input logic [7:0] c);
    open_win(); send_bits(c, 8); close_win();
    if (c[7:6] == 2'b01) begin
      exp_wr = (c[1:0] == 2'b00);
      exp_fixed = c[2];
    end
  endtask

  // address command followed by n data bytes packed LSB-first in d
  task automatic burst(input logic [7:0] acmd, input int n, input logic [31:0] d);
    int p;
    p = acmd[4:0];
    open_win();
    send_bits(acmd, 8);
    for (int k = 0; k < n; k++) begin
      send_bits(d[8*k +: 8], 8);
      if (exp_wr && p < 22) begin
        exp_ram[p] = d[8*k +: 8];
        if (!exp_fixed) p++;
      end
    end
    close_win();
  endtask

  task automatic t_reset();
    chk("R11 disp_on", disp_on, 0);
    chk("R11 dim", dim_level, 0);
    chk("R11 scan", key_scan_en, 1);
    chk("R11 digits", disp_digits, 4);
    chk("R11 segs", disp_segs, 16);
    check_ram("R11 ram clear");
  endtask

  task automatic t_ctrl();
    one_cmd(8'h8B);  // R6, R2, R1: class 10, on, step 3
    chk("R6 on", disp_on, 1);
    chk("R6 dim", dim_level, 3);
    chk("R6 scan", key_scan_en, 1);
  endtask

  task automatic t_mode_change();
    one_cmd(8'h05);
    chk("R3 disp off", disp_on, 0);
    chk("R3 scan stop", key_scan_en, 0);
    chk("R3 digits", disp_digits, 9);
    chk("R3 segs", disp_segs, 13);
    one_cmd(8'h8F);
    chk("R6 scan resumes", key_scan_en, 1);
  endtask

  task automatic t_mode_same();
    one_cmd(8'h05);
    chk("R4 on kept", disp_on, 1);
    chk("R4 scan kept", key_scan_en, 1);
    chk("R4 dim kept", dim_level, 7);
  endtask

  task automatic t_mode_table();
    for (int c = 0; c < 8; c++) begin
      one_cmd(8'(c));
      chk("R5 digits", disp_digits, 4 + c);
      chk("R5 segs", disp_segs, (c <= 2) ? 16 : 18 - c);
    end
  endtask

  task automatic t_auto_write();
    one_cmd(8'h40);
    burst(8'hC0, 3, 32'h00C3B2A1);
    check_ram("R7 R8 auto increment");
  endtask

  task automatic t_fixed();
    one_cmd(8'h44);
    burst(8'hC5, 3, 32'h00332211);
    check_ram("R8 fixed address");
    one_cmd(8'h40);
  endtask

  task automatic t_edge();
    burst(8'hD4, 3, 32'h007C6B5A);
    check_ram("R9 end of memory");
    burst(8'hD6, 1, 32'h00000099);
    check_ram("R9 invalid address");
    burst(8'hC3, 1, 32'h000000E7);
    check_ram("R9 recovery");
  endtask

  task automatic t_abort();
    open_win();
    send_bits(8'hC8, 8);
    send_bits(8'h77, 8);
    exp_ram[8] = 8'h77;
    send_bits(8'hFF, 4);
    close_win();
    check_ram("R10 partial byte");
    one_cmd(8'h81);
    chk("R10 fresh framing on", disp_on, 0);
    chk("R10 fresh framing dim", dim_level, 1);
  endtask

  task automatic t_ignore();
    one_cmd(8'h41);
    burst(8'hC0, 1, 32'h000000FF);
    check_ram("R12 non-write mode");
    one_cmd(8'h40);
    open_win(); send_bits(8'h8E, 8); send_bits(8'h00, 8); close_win();
    chk("R12 extra byte on", disp_on, 1);
    chk("R12 extra byte dim", dim_level, 6);
    open_win(); send_bits(8'h40, 8); send_bits(8'h55, 8); close_win();
    check_ram("R12 extra byte no write");
  endtask

  initial begin
    for (int a = 0; a < 22; a++) exp_ram[a] = 8'h00;
    exp_wr = 1; exp_fixed = 0;
    rst_n = 1'b0; ser_stb_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; rd_addr = '0;
    #21 rst_n = 1'b1;
    #40;
    t_reset();
    t_ctrl();
    t_mode_change();
    t_mode_same();
    t_mode_table();
    t_auto_write();
    t_fixed();
    t_edge();
    t_abort();
    t_ignore();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule